// File: doc/BRIEF.md
# Guarded Unit Power-Gating Controller

This controller drives the sleep control of a single power-gated execution unit. Its first level is an idle-detect actuator. It counts consecutive idle cycles, gates the unit once a programmable run length is reached, and ungates it as soon as work is pending again. Each gated interval carries a fixed energy cost. An interval therefore pays off only when it outlasts a programmable break-even time. The actuator labels every interval as uncompensated (woken too early) or compensated (break-even reached).

The second level is a guard monitor. Over each evaluation window it counts compensated and uncompensated intervals. At the window's end it weighs the two counts with programmable gain and loss weights and keeps gating enabled only if the net estimate is strictly positive. While gating is disabled, the actuator still runs its state machine in shadow mode. In that mode the sleep output is never raised, but the intervals are still classified and counted, so the monitor can enable gating again once the traffic pattern favours it.

A wake-up from a real gated interval takes a programmable number of cycles, and a ready output shows when the unit may be used again. Suggested settings are an idle run of 4, a break-even time of 10 and a window of 1024 cycles.

Top module: `upg_guard_ctrl`

## Requirements
- R1: While reset is asserted, the outputs read state 0 (on), gate_enable 1, both counts 0, sleep 0 and ready 1.
- R2: The state codes are 0 for on, 1 for gated-uncompensated and 2 for gated-compensated. In state 0, with ready high and task_pending low, the state becomes 1 on the edge that completes cfg_idle_thr consecutive such cycles (a value of 0 acts as 1). A pending cycle, or a cycle with ready low, restarts the run.
- R3: In state 1, once cfg_breakeven consecutive cycles have passed without a request, the state becomes 2 and comp_count rises by one on that same edge.
- R4: A request (task_pending high) in state 1 returns the state to 0 and raises uncomp_count by one. The request takes priority over a break-even reached in the same cycle.
- R5: A request in state 2 returns the state to 0 and leaves both counts unchanged.
- R6: On the edge that ends each window of cfg_window cycles, gate_enable becomes 1 exactly when comp*cfg_gain − uncomp*cfg_loss > 0. The counts used here include any event of that final cycle. Both counts read 0 after that edge.
- R7: sleep is high exactly while the state is 1 or 2 and gate_enable was 1 on the edge that left state 0. An interval entered with gate_enable 0 is a shadow interval: it still moves through states 1 and 2 and updates the counts, but sleep stays 0 and ready stays 1.
- R8: After a request ends a real (non-shadow) interval, ready is 0 for the next cfg_wake_lat cycles and then returns to 1. Idle cycles are not counted while ready is 0.
- R9: Each count saturates at its all-ones value until the window clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_pending | input | 1 | Work present for the unit this cycle; acts as the wake request while gated |
| cfg_idle_thr | input | IDLE_W | Idle cycles required before gating |
| cfg_breakeven | input | BE_W | Gated cycles needed to repay the gating cost |
| cfg_wake_lat | input | WAKE_W | Cycles from ungating until the unit is usable |
| cfg_window | input | WIN_W | Evaluation window length in cycles |
| cfg_gain | input | WT_W | Weight of a compensated interval |
| cfg_loss | input | WT_W | Weight of an uncompensated interval |
| sleep | output | 1 | Gate control of the unit's power switch |
| ready | output | 1 | Unit is powered and settled |
| gate_enable | output | 1 | Guard decision that permits real gating |
| state | output | 2 | Actuator state code |
| comp_count | output | CNT_W | Compensated intervals in the current window |
| uncomp_count | output | CNT_W | Uncompensated intervals in the current window |

## Verification
The bench sweeps idle-run threshold, break-even time, wake latency and weights over a narrow-counter build, and compares every output each cycle against an arithmetic model. Three request patterns are used. Idle gaps of growing length, one cycle apart, land on both sides of the break-even point and separate R3 from R4 and R5. Dense half-rate traffic yields mostly early wakes, which drives gate_enable low and exposes shadow intervals. Sparse traffic yields long gated intervals that saturate the counts and bring gating back. A directed opening run checks the gating edge, the break-even edge and the ready delay by cycle count.

// File: rtl/upg_pkg.sv
package upg_pkg;

  typedef enum logic [1:0] {
    ST_ON    = 2'd0,
    ST_OFF_U = 2'd1,
    ST_OFF_C = 2'd2
  } upg_state_e;

endpackage

// File: rtl/upg_actuator.sv
module upg_actuator
  import upg_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int BE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_pending,
  input  logic              gate_enable,
  input  logic              ready_i,
  input  logic [IDLE_W-1:0] cfg_idle_thr,
  input  logic [BE_W-1:0]   cfg_breakeven,
  output upg_state_e        state_o,
  output logic              real_gate_o,
  output logic              comp_evt,
  output logic              unc_evt,
  output logic              wake_start
);

  localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};
  localparam logic [IDLE_W-1:0] IDLE_ONE = {{(IDLE_W-1){1'b0}}, 1'b1};
  localparam logic [BE_W-1:0]   OFF_MAX  = {BE_W{1'b1}};
  localparam logic [BE_W-1:0]   OFF_ONE  = {{(BE_W-1){1'b0}}, 1'b1};

  upg_state_e        st_q, st_d;
  logic [IDLE_W-1:0] idle_q, idle_d, idle_inc;
  logic [BE_W-1:0]   off_q, off_d, off_inc;
  logic              real_q, real_d;
  logic              idle_cycle;

  assign idle_inc   = (idle_q == IDLE_MAX) ? idle_q : idle_q + IDLE_ONE;
  assign off_inc    = (off_q == OFF_MAX) ? off_q : off_q + OFF_ONE;
  assign idle_cycle = !task_pending && ready_i;

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    idle_d     = idle_q;
    off_d      = off_q;
    real_d     = real_q;
    comp_evt   = 1'b0;
    unc_evt    = 1'b0;
    wake_start = 1'b0;
    case (st_q)
      ST_ON: begin
        if (idle_cycle) begin
          idle_d = idle_inc;
          if (idle_inc >= cfg_idle_thr) begin
            st_d   = ST_OFF_U;
            idle_d = '0;
            off_d  = '0;
            real_d = gate_enable;
          end
        end else begin
          idle_d = '0;
        end
      end
      ST_OFF_U: begin
        if (task_pending) begin
          st_d       = ST_ON;
          unc_evt    = 1'b1;
          wake_start = real_q;
          real_d     = 1'b0;
        end else begin
          off_d = off_inc;
          if (off_inc >= cfg_breakeven) begin
            st_d     = ST_OFF_C;
            comp_evt = 1'b1;
          end
        end
      end
      ST_OFF_C: begin
        if (task_pending) begin
          st_d       = ST_ON;
          wake_start = real_q;
          real_d     = 1'b0;
        end
      end
      default: begin
        st_d   = ST_ON;
        real_d = 1'b0;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ON;
      idle_q <= '0;
      off_q  <= '0;
      real_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idle_q <= idle_d;
      off_q  <= off_d;
      real_q <= real_d;
    end
  end

  assign state_o     = st_q;
  assign real_gate_o = real_q;

  // R3: compensated state is reachable only through the uncompensated one
  p_offc_via_offu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON) |=> (st_q != ST_OFF_C));

  // R4: a request during an uncompensated interval always wakes
  p_req_leaves_offu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF_U && task_pending) |=> (st_q == ST_ON));

  // R5: a request during a compensated interval always wakes
  p_req_leaves_offc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF_C && task_pending) |=> (st_q == ST_ON));

  // R8: no gating decision while the unit is still waking
  p_no_gate_waking_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON && !ready_i) |=> (st_q == ST_ON));

endmodule

// File: rtl/upg_wake_timer.sv
module upg_wake_timer #(
  parameter int WAKE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_start,
  input  logic [WAKE_W-1:0] cfg_wake_lat,
  output logic              wake_done
);

  localparam logic [WAKE_W-1:0] WAKE_ONE = {{(WAKE_W-1){1'b0}}, 1'b1};

  logic [WAKE_W-1:0] wcnt_q, wcnt_d;
  logic              wcnt_en;

  assign wcnt_en = wake_start || (wcnt_q != '0);

  always_comb begin
    wcnt_d = wcnt_q;
    if (wake_start) begin
      wcnt_d = cfg_wake_lat;
    end else if (wcnt_q != '0) begin
      wcnt_d = wcnt_q - WAKE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (wcnt_en) begin
      wcnt_q <= wcnt_d;
    end
  end

  assign wake_done = (wcnt_q == '0);

  // R8: the settle counter drains one step per cycle
  p_wake_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt_q != '0 && !wake_start) |=> (wcnt_q == $past(wcnt_q) - WAKE_ONE));

  // R8: a wake start loads the programmed latency
  p_wake_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_start |=> (wcnt_q == $past(cfg_wake_lat)));

endmodule

// File: rtl/upg_monitor.sv
module upg_monitor #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 12,
  parameter int WT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp_evt,
  input  logic             unc_evt,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic [WT_W-1:0]  cfg_gain,
  input  logic [WT_W-1:0]  cfg_loss,
  output logic             gate_enable,
  output logic [CNT_W-1:0] comp_cnt,
  output logic [CNT_W-1:0] unc_cnt
);

  localparam int               PW      = CNT_W + WT_W;
  localparam int               SW      = PW + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [WIN_W-1:0] WIN_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]     comp_q, unc_q, comp_nx, unc_nx, comp_d, unc_d;
  logic [WIN_W-1:0]     win_q, win_d, win_last;
  logic                 en_q, en_d;
  logic                 win_end;
  logic [PW-1:0]        gain_prod, loss_prod;
  logic signed [SW-1:0] savings;
  logic                 savings_pos;

  // Saturating event accumulation
  assign comp_nx = (comp_evt && comp_q != CNT_MAX) ? comp_q + CNT_ONE : comp_q;
  assign unc_nx  = (unc_evt && unc_q != CNT_MAX) ? unc_q + CNT_ONE : unc_q;

  assign win_last = cfg_window - WIN_ONE;
  assign win_end  = (win_q >= win_last);

  // Net-savings estimate
  assign gain_prod   = PW'(comp_nx) * PW'(cfg_gain);
  assign loss_prod   = PW'(unc_nx) * PW'(cfg_loss);
  assign savings     = $signed({1'b0, gain_prod}) - $signed({1'b0, loss_prod});
  assign savings_pos = !savings[SW-1] && (savings != '0);

  always_comb begin
    comp_d = comp_nx;
    unc_d  = unc_nx;
    win_d  = win_q + WIN_ONE;
    en_d   = en_q;
    if (win_end) begin
      comp_d = '0;
      unc_d  = '0;
      win_d  = '0;
      en_d   = savings_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
      unc_q  <= '0;
      win_q  <= '0;
      en_q   <= 1'b1;
    end else begin
      comp_q <= comp_d;
      unc_q  <= unc_d;
      win_q  <= win_d;
      if (win_end) begin
        en_q <= en_d;
      end
    end
  end

  assign gate_enable = en_q;
  assign comp_cnt    = comp_q;
  assign unc_cnt     = unc_q;

  // R6: counts are cleared after every evaluation
  p_window_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (comp_q == '0 && unc_q == '0));

  // R6: the guard decision changes only at a window end
  p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(en_q));

  // R9: a full count neither wraps nor drops inside a window
  p_comp_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_q == CNT_MAX && !win_end) |=> (comp_q == CNT_MAX));

  p_unc_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_q == CNT_MAX && !win_end) |=> (unc_q == CNT_MAX));

endmodule

// File: rtl/upg_guard_ctrl.sv
module upg_guard_ctrl
  import upg_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int BE_W   = 8,
  parameter int WAKE_W = 6,
  parameter int WIN_W  = 12,
  parameter int WT_W   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_pending,
  input  logic [IDLE_W-1:0] cfg_idle_thr,
  input  logic [BE_W-1:0]   cfg_breakeven,
  input  logic [WAKE_W-1:0] cfg_wake_lat,
  input  logic [WIN_W-1:0]  cfg_window,
  input  logic [WT_W-1:0]   cfg_gain,
  input  logic [WT_W-1:0]   cfg_loss,
  output logic              sleep,
  output logic              ready,
  output logic              gate_enable,
  output logic [1:0]        state,
  output logic [CNT_W-1:0]  comp_count,
  output logic [CNT_W-1:0]  uncomp_count
);

  upg_state_e act_state;
  logic       real_gate;
  logic       comp_evt, unc_evt, wake_start, wake_done;
  logic       en;

  upg_actuator #(
    .IDLE_W(IDLE_W),
    .BE_W  (BE_W)
  ) u_act (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_pending (task_pending),
    .gate_enable  (en),
    .ready_i      (wake_done),
    .cfg_idle_thr (cfg_idle_thr),
    .cfg_breakeven(cfg_breakeven),
    .state_o      (act_state),
    .real_gate_o  (real_gate),
    .comp_evt     (comp_evt),
    .unc_evt      (unc_evt),
    .wake_start   (wake_start)
  );

  upg_wake_timer #(
    .WAKE_W(WAKE_W)
  ) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_start  (wake_start),
    .cfg_wake_lat(cfg_wake_lat),
    .wake_done   (wake_done)
  );

  upg_monitor #(
    .CNT_W(CNT_W),
    .WIN_W(WIN_W),
    .WT_W (WT_W)
  ) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .comp_evt   (comp_evt),
    .unc_evt    (unc_evt),
    .cfg_window (cfg_window),
    .cfg_gain   (cfg_gain),
    .cfg_loss   (cfg_loss),
    .gate_enable(en),
    .comp_cnt   (comp_count),
    .unc_cnt    (uncomp_count)
  );

  assign sleep       = (act_state != ST_ON) && real_gate;
  assign ready       = !sleep && wake_done;
  assign gate_enable = en;
  assign state       = act_state;

  // R7: the switch closes only when the guard permitted it
  p_gate_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(en));

  // R7: sleep falls only on a wake request
  p_sleep_falls_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> $past(task_pending));

endmodule

// File: tb/tb_upg_guard_ctrl.sv
`timescale 1ns/1ps
module tb_upg_guard_ctrl;

  localparam int IDLE_W = 4;
  localparam int BE_W   = 4;
  localparam int WAKE_W = 3;
  localparam int WIN_W  = 8;
  localparam int WT_W   = 3;
  localparam int CNT_W  = 3;
  localparam int IMAX   = (1 << IDLE_W) - 1;
  localparam int BMAX   = (1 << BE_W) - 1;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pend;
  logic [IDLE_W-1:0] cfg_idle_thr;
  logic [BE_W-1:0]   cfg_breakeven;
  logic [WAKE_W-1:0] cfg_wake_lat;
  logic [WIN_W-1:0]  cfg_window;
  logic [WT_W-1:0]   cfg_gain, cfg_loss;
  logic              sleep, ready, gate_enable;
  logic [1:0]        state;
  logic [CNT_W-1:0]  comp_count, uncomp_count;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  upg_guard_ctrl #(
    .IDLE_W(IDLE_W), .BE_W(BE_W), .WAKE_W(WAKE_W),
    .WIN_W(WIN_W), .WT_W(WT_W), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .task_pending(pend),
    .cfg_idle_thr(cfg_idle_thr), .cfg_breakeven(cfg_breakeven),
    .cfg_wake_lat(cfg_wake_lat), .cfg_window(cfg_window),
    .cfg_gain(cfg_gain), .cfg_loss(cfg_loss),
    .sleep(sleep), .ready(ready), .gate_enable(gate_enable),
    .state(state), .comp_count(comp_count), .uncomp_count(uncomp_count)
  );

  // Reference model, derived from the requirement list
  int m_st, m_idle, m_off, m_real, m_wk, m_en, m_c, m_u, m_win;

  always @(posedge clk) begin
    int ec, eu, ws, nc, nu, sav, thr;
    if (!rst_n) begin
      m_st = 0; m_idle = 0; m_off = 0; m_real = 0; m_wk = 0;
      m_en = 1; m_c = 0; m_u = 0; m_win = 0;
    end else begin
      ec = 0; eu = 0; ws = 0;
      thr = (int'(cfg_idle_thr) == 0) ? 1 : int'(cfg_idle_thr);
      if (m_st == 0) begin
        if (!pend && m_wk == 0) begin
          m_idle = (m_idle < IMAX) ? m_idle + 1 : IMAX;
          if (m_idle >= thr) begin
            m_st = 1; m_idle = 0; m_off = 0; m_real = m_en;
          end
        end else m_idle = 0;
      end else if (m_st == 1) begin
        if (pend) begin
          m_st = 0; eu = 1; ws = m_real; m_real = 0;
        end else begin
          m_off = (m_off < BMAX) ? m_off + 1 : BMAX;
          if (m_off >= int'(cfg_breakeven)) begin m_st = 2; ec = 1; end
        end
      end else begin
        if (pend) begin m_st = 0; ws = m_real; m_real = 0; end
      end
      if (ws != 0) m_wk = int'(cfg_wake_lat);
      else if (m_wk != 0) m_wk = m_wk - 1;
      nc = (m_c + ec > CMAX) ? CMAX : m_c + ec;
      nu = (m_u + eu > CMAX) ? CMAX : m_u + eu;
      if (m_win >= int'(cfg_window) - 1) begin
        sav  = nc * int'(cfg_gain) - nu * int'(cfg_loss);
        m_en = (sav > 0) ? 1 : 0;
        m_c = 0; m_u = 0; m_win = 0;
      end else begin
        m_c = nc; m_u = nu; m_win = m_win + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_sleep;
    e_sleep = (m_st != 0 && m_real != 0) ? 1 : 0;
    chk("R2/R3/R5 state", 32'(state), 32'(m_st));
    chk("R3 R9 comp_count", 32'(comp_count), 32'(m_c));
    chk("R4 R9 uncomp_count", 32'(uncomp_count), 32'(m_u));
    chk("R6 gate_enable", 32'(gate_enable), 32'(m_en));
    chk("R7 sleep", 32'(sleep), 32'(e_sleep));
    chk("R8 ready", 32'(ready), 32'((e_sleep == 0 && m_wk == 0) ? 1 : 0));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic reset_and_check();
    @(negedge clk);
    rst_n = 1'b0;
    pend  = 1'b0;
    @(negedge clk);
    chk("R1 state", 32'(state), 0);
    chk("R1 gate_enable", 32'(gate_enable), 1);
    chk("R1 comp_count", 32'(comp_count), 0);
    chk("R1 uncomp_count", 32'(uncomp_count), 0);
    chk("R1 sleep", 32'(sleep), 0);
    chk("R1 ready", 32'(ready), 1);
    rst_n = 1'b1;
  endtask

  initial begin
    bit [15:0] lfsr;
    rst_n = 1'b0;
    pend  = 1'b0;
    cfg_idle_thr = 4'd3; cfg_breakeven = 4'd4; cfg_wake_lat = 3'd2;
    cfg_window = 8'd200; cfg_gain = 3'd1; cfg_loss = 3'd1;
    lfsr = 16'hACE1;

    // Directed opening run: closed-form cycle positions
    reset_and_check();
    step(); step();
    chk("R2 still on before threshold", 32'(state), 0);
    step();
    chk("R2 gated after 3 idle cycles", 32'(state), 1);
    chk("R7 sleep with enable", 32'(sleep), 1);
    step(); step(); step();
    chk("R3 not yet at break-even", 32'(state), 1);
    step();
    chk("R3 compensated after 4 gated cycles", 32'(state), 2);
    chk("R3 comp_count", 32'(comp_count), 1);
    pend = 1'b1;
    step();
    pend = 1'b0;
    chk("R5 woken", 32'(state), 0);
    chk("R5 counts kept", 32'(uncomp_count), 0);
    chk("R8 ready low 1", 32'(ready), 0);
    step();
    chk("R8 ready low 2", 32'(ready), 0);
    step();
    chk("R8 ready back", 32'(ready), 1);

    // Configuration sweep under three traffic patterns
    for (int cfg = 0; cfg < 18; cfg++) begin
      cfg_idle_thr  = IDLE_W'(1 + cfg % 3);
      cfg_breakeven = BE_W'((cfg / 3) % 3 * 2 + 1);
      cfg_wake_lat  = WAKE_W'(((cfg / 9) % 2) * 2);
      cfg_gain      = WT_W'(1 + cfg % 3);
      cfg_loss      = WT_W'(1 + (cfg / 2) % 4);
      cfg_window    = WIN_W'(((cfg % 2) == 0) ? 24 : 40);
      reset_and_check();
      // Idle gaps of growing length around the break-even point
      for (int gap = 0; gap < 14; gap++) begin
        for (int k = 0; k < gap; k++) begin pend = 1'b0; step(); end
        pend = 1'b1; step();
        pend = 1'b0;
        for (int k = 0; k < cfg_wake_lat; k++) step();
      end
      // Dense traffic: mostly early wakes
      for (int k = 0; k < 150; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pend = lfsr[0];
        step();
      end
      // Sparse traffic: long gated intervals
      for (int k = 0; k < 200; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pend = (lfsr[2:0] == 3'b000);
        step();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule